// File: doc/BRIEF.md
# Accumulator 8-bit Execute Core

This block is the execute stage of a small accumulator-style 8-bit processor. Each cycle in which `instr_valid` is high, it decodes one 13-bit instruction word and executes it. It updates an 8-bit accumulator, a 64-entry 8-bit register file, a control register, sixteen I/O control registers, the zero, carry and digit-carry flags, an interrupt-enable bit and an eight-deep return-address stack.

A fetch unit outside the block supplies the word together with the program counter of that word. The fetch unit reads back the registered next program counter. It also pushes return addresses through `push_req` when it handles a call, because call and jump opcodes are not decoded here.

Sleep and watchdog-clear requests leave the block as one-cycle pulses for the power and watchdog logic. An opcode the block does not recognise runs as a no-op and raises a one-cycle illegal-instruction pulse. All outputs are registered, so the result of an instruction is visible one clock after the edge that accepts it.

Top module: `acc8_exec_core`

## Requirements
- R1: Synchronous active-high reset clears all of the following: the accumulator, the register file, the control register, the I/O control registers, Z, C and DC, the interrupt-enable bit, `next_pc`, every pulse output, the return stack and its underflow flag.
- R2: The word is split into an operation field in bits [12:6] and a register field in bits [5:0]. In each operation pair, the even code writes the accumulator and the odd code writes the register. The pairs are:
  - OR at 0x08/0x09
  - AND at 0x0A/0x0B
  - XOR at 0x0C/0x0D
  - decrement at 0x06/0x07
  - complement at 0x12/0x13

  Increment (0x14) writes R+1 to the accumulator. All of these update Z only.
- R3: Subtract (0x04 writes A, 0x05 writes R) computes R minus A. C is 1 when no borrow occurs. DC is 1 when the low nibble of R minus the low nibble of A needs no borrow. Z is set from the result.
- R4: Add (0x0E writes A, 0x0F writes R) computes A plus R. C is the carry out of bit 7, DC is the carry out of bit 3, and Z is set from the result.
- R5: The following change no flag: moving A to a register (0x01), CONTW (word 0x002), CONTR (0x014), the I/O write and read forms, ENI, DISI, NOP, RET and RETI. The Z-only operations leave C and DC unchanged.
- R6: Decimal adjust (word 0x001) first adds 0x06 when the low nibble of A is above 9 or DC is set. It then adds 0x60 when the high nibble of that intermediate value is above 9 or C is set. C becomes 1 exactly when the 0x60 step is applied. Z and DC are unchanged.
- R7: The move and clear operations behave as follows:
  - Op 0x01 copies A into R.
  - Op 0x10 copies R into A and sets Z.
  - Op 0x11 writes R back to itself and sets Z from it.
  - Op 0x03 clears R and sets Z.
  - Word 0x080 clears A and sets Z.
- R8: Word 0x002 copies A into the control register, and word 0x014 copies the control register into A. Words 0x005–0x00F write A to the I/O control register selected by bits [3:0]. Words 0x015–0x01F read that register into A.
- R9: Word 0x010 sets the interrupt-enable bit and word 0x011 clears it. Word 0x013 sets it while returning.
- R10: Words 0x012 and 0x013 load `next_pc` from the top of the return stack and pulse `ret_taken`. Every other executed word loads `pc_in + 1`. A push writes `push_addr` on top of the stack. A ninth push overwrites the oldest entry. When a return and a push fall in the same cycle, the return reads the old top and the pushed address replaces it.
- R11: A return from an empty stack yields address 0 and sets `stack_underflow`, which stays set until reset.
- R12: Word 0x003 pulses both `sleep_pulse` and `wdt_clear_pulse`. Word 0x004 pulses only `wdt_clear_pulse`. Each pulse is high for the cycle after the instruction is accepted.
- R13: Any word outside the decoded set changes no state and pulses `illegal_pulse` for one cycle. This includes op 0x02 with a nonzero register field, op 0x00 with bits [5:4] of 2 or 3, and ops 0x15–0x7F.
- R14: While `instr_valid` is low, the accumulator, flags, registers and `next_pc` hold, and no instruction pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Execute `instr` this cycle |
| instr | input | 13 | Instruction word |
| pc_in | input | PCW | Address of the instruction word |
| push_req | input | 1 | Push `push_addr` onto the return stack |
| push_addr | input | PCW | Return address to push |
| next_pc | output | PCW | Registered next program counter |
| ret_taken | output | 1 | Last executed word was a return |
| sleep_pulse | output | 1 | Sleep request pulse |
| wdt_clear_pulse | output | 1 | Watchdog clear pulse |
| illegal_pulse | output | 1 | Undecoded opcode pulse |
| acc_q | output | 8 | Accumulator |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_dc | output | 1 | Digit-carry flag |
| int_en | output | 1 | Interrupt-enable bit |
| stack_underflow | output | 1 | Sticky empty-pop flag |

## Verification
A wrong flag or register value seldom appears at once. It surfaces when a later instruction reads it: an add or subtract that consumes it, a move into the accumulator, or a decimal adjust that depends on C and DC. The bench therefore compares the accumulator, all three flags, `next_pc` and the pulses against a reference model after every single instruction. This catches a divergence at the first instruction that exposes it. A corrupted return-stack pointer shows only on the next return, through `next_pc`. For that reason, the directed pushes and returns reach wrap-around and underflow.

// File: rtl/acc8_pkg.sv
package acc8_pkg;
    localparam int unsigned IW   = 13;
    localparam int unsigned DW   = 8;
    localparam int unsigned RAW  = 6;
    localparam int unsigned IOAW = 4;
    localparam int unsigned NREG = 1 << RAW;
    localparam int unsigned NIO  = 1 << IOAW;

    typedef enum logic [4:0] {
        OP_NOP, OP_DAA, OP_CONTW, OP_SLEP, OP_WDTC, OP_IOW, OP_ENI, OP_DISI,
        OP_RET, OP_RETI, OP_CONTR, OP_IOR, OP_MOVRA, OP_CLRA, OP_CLR, OP_SUB,
        OP_DEC, OP_OR, OP_AND, OP_XOR, OP_ADD, OP_MOVAR, OP_MOVRR, OP_COM, OP_INC
    } op_e;

    typedef struct packed {
        op_e             op;
        logic            to_reg;
        logic [RAW-1:0]  ra;
        logic [IOAW-1:0] ioa;
        logic            illegal;
    } dec_s;

    typedef struct packed {
        logic [DW-1:0] res;
        logic          we_a;
        logic          we_r;
        logic          z, c, dc;
        logic          wz, wc, wdc;
    } alu_s;

    // returns {carry7, carry3, sum}
    function automatic logic [DW+1:0] add_nib(input logic [DW-1:0] a,
                                              input logic [DW-1:0] b,
                                              input logic cin);
        logic [DW:0] full;
        logic [4:0]  low;
        full = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
        low  = {1'b0, a[3:0]} + {1'b0, b[3:0]} + {4'b0, cin};
        return {full[DW], low[4], full[DW-1:0]};
    endfunction
endpackage

// File: rtl/acc8_decode.sv
module acc8_decode
    import acc8_pkg::*;
(
    input  logic [IW-1:0] word,
    output dec_s          dec
);
    logic [6:0]     grp;
    logic [RAW-1:0] lo;

    assign grp = word[12:6];
    assign lo  = word[RAW-1:0];

    always_comb begin
        dec.op      = OP_NOP;
        dec.to_reg  = word[6];
        dec.ra      = lo;
        dec.ioa     = lo[IOAW-1:0];
        dec.illegal = 1'b0;
        casez (grp)
            7'b0000000: begin
                case (lo[5:4])
                    2'b00: case (lo[3:0])
                        4'd0:    dec.op = OP_NOP;
                        4'd1:    dec.op = OP_DAA;
                        4'd2:    dec.op = OP_CONTW;
                        4'd3:    dec.op = OP_SLEP;
                        4'd4:    dec.op = OP_WDTC;
                        default: dec.op = OP_IOW;
                    endcase
                    2'b01: case (lo[3:0])
                        4'd0:    dec.op = OP_ENI;
                        4'd1:    dec.op = OP_DISI;
                        4'd2:    dec.op = OP_RET;
                        4'd3:    dec.op = OP_RETI;
                        4'd4:    dec.op = OP_CONTR;
                        default: dec.op = OP_IOR;
                    endcase
                    default: dec.illegal = 1'b1;
                endcase
            end
            7'b0000001: dec.op = OP_MOVRA;
            7'b0000010: begin
                if (lo == '0) dec.op = OP_CLRA;
                else          dec.illegal = 1'b1;
            end
            7'b0000011: dec.op = OP_CLR;
            7'b000010?: dec.op = OP_SUB;
            7'b000011?: dec.op = OP_DEC;
            7'b000100?: dec.op = OP_OR;
            7'b000101?: dec.op = OP_AND;
            7'b000110?: dec.op = OP_XOR;
            7'b000111?: dec.op = OP_ADD;
            7'b0010000: dec.op = OP_MOVAR;
            7'b0010001: dec.op = OP_MOVRR;
            7'b001001?: dec.op = OP_COM;
            7'b0010100: dec.op = OP_INC;
            default:    dec.illegal = 1'b1;
        endcase
    end
endmodule

// File: rtl/acc8_alu.sv
module acc8_alu
    import acc8_pkg::*;
(
    input  dec_s          dec,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] r,
    input  logic [DW-1:0] ext,
    input  logic          c_in,
    input  logic          dc_in,
    output alu_s          out
);
    logic [DW+1:0] sum_add, sum_sub;
    logic [DW-1:0] daa_lo, daa_hi;
    logic          daa_hi_adj;

    assign sum_add = add_nib(a, r, 1'b0);
    assign sum_sub = add_nib(r, ~a, 1'b1);

    always_comb begin
        daa_lo     = (a[3:0] > 4'd9 || dc_in) ? a + 8'h06 : a;
        daa_hi_adj = (daa_lo[7:4] > 4'd9) || c_in;
        daa_hi     = daa_hi_adj ? daa_lo + 8'h60 : daa_lo;
    end

    always_comb begin
        out      = '0;
        out.we_r = dec.to_reg;
        out.we_a = ~dec.to_reg;
        out.wz   = 1'b1;
        case (dec.op)
            OP_SUB: begin
                out.res = sum_sub[DW-1:0];
                out.c   = sum_sub[DW+1];
                out.dc  = sum_sub[DW];
                out.wc  = 1'b1;
                out.wdc = 1'b1;
            end
            OP_ADD: begin
                out.res = sum_add[DW-1:0];
                out.c   = sum_add[DW+1];
                out.dc  = sum_add[DW];
                out.wc  = 1'b1;
                out.wdc = 1'b1;
            end
            OP_DEC:              out.res = r - 8'd1;
            OP_INC:              out.res = r + 8'd1;
            OP_OR:               out.res = a | r;
            OP_AND:              out.res = a & r;
            OP_XOR:              out.res = a ^ r;
            OP_COM:              out.res = ~r;
            OP_MOVAR, OP_MOVRR:  out.res = r;
            OP_CLR, OP_CLRA:     out.res = '0;
            OP_MOVRA: begin
                out.res = a;
                out.wz  = 1'b0;
            end
            OP_DAA: begin
                out.res  = daa_hi;
                out.we_a = 1'b1;
                out.we_r = 1'b0;
                out.wz   = 1'b0;
                out.c    = daa_hi_adj;
                out.wc   = 1'b1;
            end
            OP_CONTR, OP_IOR: begin
                out.res  = ext;
                out.we_a = 1'b1;
                out.we_r = 1'b0;
                out.wz   = 1'b0;
            end
            default: begin
                out.we_a = 1'b0;
                out.we_r = 1'b0;
                out.wz   = 1'b0;
            end
        endcase
        out.z = (out.res == '0);
    end
endmodule

// File: rtl/acc8_ret_stack.sv
module acc8_ret_stack #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned AW    = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic          pop,
    output logic [AW-1:0] pop_addr,
    output logic          underflow
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [AW-1:0] mem [DEPTH];
    logic [PW-1:0] sp, sp_dn, sp_up;
    logic [CW-1:0] cnt;
    logic          empty;

    assign empty    = (cnt == '0);
    assign sp_dn    = (sp == '0) ? PW'(DEPTH - 1) : sp - 1'b1;
    assign sp_up    = (sp == PW'(DEPTH - 1)) ? '0 : sp + 1'b1;
    assign pop_addr = empty ? '0 : mem[sp_dn];

    always_ff @(posedge clk) begin
        if (rst) begin
            sp        <= '0;
            cnt       <= '0;
            underflow <= 1'b0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (pop && empty) underflow <= 1'b1;
            if (pop && push) begin
                if (empty) begin
                    mem[sp] <= push_addr;
                    sp      <= sp_up;
                    cnt     <= CW'(1);
                end else begin
                    mem[sp_dn] <= push_addr;
                end
            end else if (pop) begin
                if (!empty) begin
                    sp  <= sp_dn;
                    cnt <= cnt - 1'b1;
                end
            end else if (push) begin
                mem[sp] <= push_addr;
                sp      <= sp_up;
                if (cnt != CW'(DEPTH)) cnt <= cnt + 1'b1;
            end
        end
    end

    // R10
    depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));

    // R11
    underflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        underflow |=> underflow);

    // R11
    empty_pop_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && empty) |=> underflow);
endmodule

// File: rtl/acc8_exec_core.sv
module acc8_exec_core
    import acc8_pkg::*;
#(
    parameter int unsigned PCW         = 10,
    parameter int unsigned STACK_DEPTH = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           instr_valid,
    input  logic [12:0]    instr,
    input  logic [PCW-1:0] pc_in,
    input  logic           push_req,
    input  logic [PCW-1:0] push_addr,
    output logic [PCW-1:0] next_pc,
    output logic           ret_taken,
    output logic           sleep_pulse,
    output logic           wdt_clear_pulse,
    output logic           illegal_pulse,
    output logic [7:0]     acc_q,
    output logic           flag_z,
    output logic           flag_c,
    output logic           flag_dc,
    output logic           int_en,
    output logic           stack_underflow
);
    dec_s          dec;
    alu_s          alu;
    logic [DW-1:0] rf   [NREG];
    logic [DW-1:0] iocr [NIO];
    logic [DW-1:0] ctrl_q;
    logic [DW-1:0] ext_val;
    logic          exec, is_ret;
    logic [PCW-1:0] ret_addr;

    acc8_decode u_dec (.word(instr), .dec(dec));

    assign ext_val = (dec.op == OP_CONTR) ? ctrl_q : iocr[dec.ioa];

    acc8_alu u_alu (
        .dec(dec), .a(acc_q), .r(rf[dec.ra]), .ext(ext_val),
        .c_in(flag_c), .dc_in(flag_dc), .out(alu)
    );

    assign exec   = instr_valid && !dec.illegal;
    assign is_ret = exec && (dec.op == OP_RET || dec.op == OP_RETI);

    acc8_ret_stack #(.DEPTH(STACK_DEPTH), .AW(PCW)) u_stk (
        .clk(clk), .rst(rst), .push(push_req), .push_addr(push_addr),
        .pop(is_ret), .pop_addr(ret_addr), .underflow(stack_underflow)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            ctrl_q  <= '0;
            flag_z  <= 1'b0;
            flag_c  <= 1'b0;
            flag_dc <= 1'b0;
            int_en  <= 1'b0;
            for (int i = 0; i < NREG; i++) rf[i] <= '0;
            for (int i = 0; i < NIO; i++)  iocr[i] <= '0;
        end else if (exec) begin
            if (alu.we_a) acc_q <= alu.res;
            if (alu.we_r) rf[dec.ra] <= alu.res;
            if (alu.wz)   flag_z  <= alu.z;
            if (alu.wc)   flag_c  <= alu.c;
            if (alu.wdc)  flag_dc <= alu.dc;
            case (dec.op)
                OP_CONTW:        ctrl_q <= acc_q;
                OP_IOW:          iocr[dec.ioa] <= acc_q;
                OP_ENI, OP_RETI: int_en <= 1'b1;
                OP_DISI:         int_en <= 1'b0;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            next_pc         <= '0;
            ret_taken       <= 1'b0;
            sleep_pulse     <= 1'b0;
            wdt_clear_pulse <= 1'b0;
            illegal_pulse   <= 1'b0;
        end else begin
            ret_taken       <= is_ret;
            sleep_pulse     <= exec && dec.op == OP_SLEP;
            wdt_clear_pulse <= exec && (dec.op == OP_SLEP || dec.op == OP_WDTC);
            illegal_pulse   <= instr_valid && dec.illegal;
            if (instr_valid) next_pc <= is_ret ? ret_addr : pc_in + 1'b1;
        end
    end

    // R12
    sleep_implies_wdt_chk: assert property (@(posedge clk) disable iff (rst)
        sleep_pulse |-> wdt_clear_pulse);

    // R13
    illegal_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        illegal_pulse |-> $past(instr_valid));

    // R14
    idle_holds_state_chk: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |=> $stable({acc_q, flag_z, flag_c, flag_dc, int_en, next_pc}));

    // R10
    ret_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        ret_taken |-> $past(instr_valid) && !illegal_pulse);

    // R13
    illegal_no_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && dec.illegal) |=> $stable({acc_q, flag_z, flag_c, flag_dc, int_en}));
endmodule

// File: tb/acc8_exec_core_tb.sv
`timescale 1ns/1ps
module acc8_exec_core_tb_top;
    localparam int PCW = 10;

    logic           clk = 1'b0;
    logic           rst;
    logic           instr_valid;
    logic [12:0]    instr;
    logic [PCW-1:0] pc_in;
    logic           push_req;
    logic [PCW-1:0] push_addr;
    logic [PCW-1:0] next_pc;
    logic           ret_taken, sleep_pulse, wdt_clear_pulse, illegal_pulse;
    logic [7:0]     acc_q;
    logic           flag_z, flag_c, flag_dc, int_en, stack_underflow;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    acc8_exec_core #(.PCW(PCW), .STACK_DEPTH(8)) dut_i (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
        .pc_in(pc_in), .push_req(push_req), .push_addr(push_addr),
        .next_pc(next_pc), .ret_taken(ret_taken), .sleep_pulse(sleep_pulse),
        .wdt_clear_pulse(wdt_clear_pulse), .illegal_pulse(illegal_pulse),
        .acc_q(acc_q), .flag_z(flag_z), .flag_c(flag_c), .flag_dc(flag_dc),
        .int_en(int_en), .stack_underflow(stack_underflow)
    );

    // reference model state
    logic [7:0]     m_rf [64];
    logic [7:0]     m_io [16];
    logic [7:0]     m_ctrl, m_acc;
    logic           m_z, m_c, m_dc, m_ie, m_uf;
    logic [PCW-1:0] m_stk [8];
    int             m_sp, m_cnt;
    logic [PCW-1:0] m_npc;
    logic           e_ret, e_slp, e_wdt, e_ill;
    string          tag;

    task automatic check(input bit ok, input string rq, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 64; i++) m_rf[i] = 8'h00;
        for (int i = 0; i < 16; i++) m_io[i] = 8'h00;
        for (int i = 0; i < 8; i++)  m_stk[i] = '0;
        m_ctrl = 0; m_acc = 0; m_z = 0; m_c = 0; m_dc = 0; m_ie = 0; m_uf = 0;
        m_sp = 0; m_cnt = 0; m_npc = 0;
        e_ret = 0; e_slp = 0; e_wdt = 0; e_ill = 0;
    endtask

    task automatic model_stack(input bit pop, input bit push, input logic [PCW-1:0] pa,
                               output logic [PCW-1:0] top);
        top = (m_cnt > 0) ? m_stk[(m_sp + 7) % 8] : '0;
        if (pop && m_cnt == 0) m_uf = 1'b1;
        if (pop && push) begin
            if (m_cnt == 0) begin m_stk[m_sp] = pa; m_sp = (m_sp + 1) % 8; m_cnt = 1; end
            else m_stk[(m_sp + 7) % 8] = pa;
        end else if (pop) begin
            if (m_cnt > 0) begin m_sp = (m_sp + 7) % 8; m_cnt--; end
        end else if (push) begin
            m_stk[m_sp] = pa; m_sp = (m_sp + 1) % 8;
            if (m_cnt < 8) m_cnt++;
        end
    endtask

    task automatic put(input logic [12:0] w, input logic [7:0] v);
        if (w[6]) m_rf[w[5:0]] = v; else m_acc = v;
    endtask

    task automatic model_exec(input bit v, input logic [12:0] w, input logic [PCW-1:0] pc,
                              input bit push, input logic [PCW-1:0] pa);
        logic [6:0] g;
        logic [5:0] lo;
        logic [7:0] a, r, t;
        logic [8:0] s;
        logic [4:0] n;
        bit pop;
        logic [PCW-1:0] top;
        g = w[12:6]; lo = w[5:0]; a = m_acc; r = m_rf[lo];
        e_ret = 0; e_slp = 0; e_wdt = 0; e_ill = 0; pop = 0;
        tag = "R14";
        if (v) begin
            tag = "R2";
            case (g)
                7'h00: begin
                    tag = "R8";
                    if (lo[5:4] == 2'b00) begin
                        case (lo[3:0])
                            4'd0: tag = "R5";
                            4'd1: begin
                                tag = "R6";
                                t = (a[3:0] > 9 || m_dc) ? a + 8'h06 : a;
                                if (t[7:4] > 9 || m_c) begin t = t + 8'h60; m_c = 1; end
                                else m_c = 0;
                                m_acc = t;
                            end
                            4'd2: m_ctrl = a;
                            4'd3: begin tag = "R12"; e_slp = 1; e_wdt = 1; end
                            4'd4: begin tag = "R12"; e_wdt = 1; end
                            default: m_io[lo[3:0]] = a;
                        endcase
                    end else if (lo[5:4] == 2'b01) begin
                        case (lo[3:0])
                            4'd0: begin tag = "R9"; m_ie = 1; end
                            4'd1: begin tag = "R9"; m_ie = 0; end
                            4'd2: begin tag = "R10"; pop = 1; end
                            4'd3: begin tag = "R10"; pop = 1; m_ie = 1; end
                            4'd4: m_acc = m_ctrl;
                            default: m_acc = m_io[lo[3:0]];
                        endcase
                    end else begin tag = "R13"; e_ill = 1; end
                end
                7'h01: begin tag = "R7"; m_rf[lo] = a; end
                7'h02: begin
                    tag = "R7";
                    if (lo == 0) begin m_acc = 0; m_z = 1; end
                    else begin tag = "R13"; e_ill = 1; end
                end
                7'h03: begin tag = "R7"; m_rf[lo] = 0; m_z = 1; end
                7'h04, 7'h05: begin
                    tag = "R3";
                    s = {1'b0, r} - {1'b0, a};
                    n = {1'b0, r[3:0]} - {1'b0, a[3:0]};
                    m_c = ~s[8]; m_dc = ~n[4]; m_z = (s[7:0] == 0); put(w, s[7:0]);
                end
                7'h06, 7'h07: begin t = r - 1; m_z = (t == 0); put(w, t); end
                7'h08, 7'h09: begin t = a | r; m_z = (t == 0); put(w, t); end
                7'h0A, 7'h0B: begin t = a & r; m_z = (t == 0); put(w, t); end
                7'h0C, 7'h0D: begin t = a ^ r; m_z = (t == 0); put(w, t); end
                7'h0E, 7'h0F: begin
                    tag = "R4";
                    s = {1'b0, a} + {1'b0, r};
                    n = {1'b0, a[3:0]} + {1'b0, r[3:0]};
                    m_c = s[8]; m_dc = n[4]; m_z = (s[7:0] == 0); put(w, s[7:0]);
                end
                7'h10, 7'h11: begin tag = "R7"; m_z = (r == 0); put(w, r); end
                7'h12, 7'h13: begin t = ~r; m_z = (t == 0); put(w, t); end
                7'h14: begin t = r + 1; m_z = (t == 0); m_acc = t; end
                default: begin tag = "R13"; e_ill = 1; end
            endcase
        end
        model_stack(pop, push, pa, top);
        e_ret = pop;
        if (v) m_npc = pop ? top : pc + 1'b1;
    endtask

    task automatic compare();
        check(acc_q === m_acc, tag, "acc", acc_q, m_acc);
        check({flag_z, flag_c, flag_dc} === {m_z, m_c, m_dc}, tag, "flags ZCDC",
              {flag_z, flag_c, flag_dc}, {m_z, m_c, m_dc});
        check(int_en === m_ie, tag, "int_en", int_en, m_ie);
        check(next_pc === m_npc, tag, "next_pc", next_pc, m_npc);
        check({ret_taken, sleep_pulse, wdt_clear_pulse, illegal_pulse} ===
              {e_ret, e_slp, e_wdt, e_ill}, tag, "pulses ret/slp/wdt/ill",
              {ret_taken, sleep_pulse, wdt_clear_pulse, illegal_pulse},
              {e_ret, e_slp, e_wdt, e_ill});
        check(stack_underflow === m_uf, tag, "underflow", stack_underflow, m_uf);
    endtask

    // called at a negedge; returns at the next negedge
    task automatic step(input bit v, input logic [12:0] w, input bit push,
                        input logic [PCW-1:0] pa);
        logic [PCW-1:0] pc;
        pc = PCW'($urandom);
        instr_valid = v; instr = w; pc_in = pc; push_req = push; push_addr = pa;
        model_exec(v, w, pc, push, pa);
        @(negedge clk);
        compare();
    endtask

    function automatic logic [12:0] rand_word();
        int k;
        k = $urandom % 10;
        if (k < 6) return {7'($urandom % 21), 6'($urandom)};
        if (k == 6) return 13'($urandom);
        if (k == 7) return 13'h080;
        return {7'h00, 2'b00, 4'($urandom)} | (($urandom % 2) != 0 ? 13'h010 : 13'h000);
    endfunction

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                failures++;
                checks++;
                $display("FAIL watchdog expired");
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1; instr_valid = 0; instr = '0; pc_in = '0; push_req = 0; push_addr = '0;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        tag = "R1";
        compare();
        // R1: register file cleared -> MOV A,R63 gives 0 with Z set
        step(1, {7'h10, 6'd63}, 0, '0);
        check(acc_q === 8'h00 && flag_z === 1'b1, "R1", "cleared register", acc_q, 0);
        // R11: return on empty stack
        step(1, 13'h012, 0, '0);
        check(next_pc === '0 && stack_underflow === 1'b1, "R11", "empty pop", next_pc, 0);
        // R10: ten pushes, oldest two overwritten, then nine returns
        for (int i = 0; i < 10; i++) step(0, 13'h000, 1, PCW'(16 + i));
        for (int i = 0; i < 9; i++) begin
            step(1, 13'h012, 0, '0);
            check(next_pc === ((i < 8) ? PCW'(25 - i) : '0), "R10", "stack order",
                  next_pc, (i < 8) ? 25 - i : 0);
        end
        // R10: simultaneous push and return
        step(0, 13'h000, 1, PCW'(100));
        step(1, 13'h013, 1, PCW'(200));
        check(next_pc === PCW'(100) && int_en === 1'b1, "R10", "pop+push old top", next_pc, 100);
        step(1, 13'h012, 0, '0);
        check(next_pc === PCW'(200), "R10", "pushed replaces top", next_pc, 200);
        // R13: undecoded words
        step(1, 13'h1FFF, 0, '0);
        step(1, 13'h0081, 0, '0);
        step(1, 13'h0025, 0, '0);
        // R12: sleep then watchdog clear, back to back
        step(1, 13'h003, 0, '0);
        step(1, 13'h004, 0, '0);
        step(1, 13'h000, 0, '0);
        // R5: NOP/ENI/DISI flags untouched after creating Z via CLRA
        step(1, 13'h080, 0, '0);
        step(1, 13'h010, 0, '0);
        step(1, 13'h011, 0, '0);
        check(flag_z === 1'b1 && int_en === 1'b0, "R5", "flags kept by ENI/DISI", flag_z, 1);
        // R14: idle cycles
        for (int i = 0; i < 4; i++) step(0, 13'($urandom), 0, '0);
        // random mix covering R2 R3 R4 R6 R7 R8 and the rest
        for (int i = 0; i < 4000; i++) begin
            bit v;
            bit p;
            v = ($urandom % 10) != 0;
            p = ($urandom % 12) == 0;
            step(v, rand_word(), p, PCW'($urandom));
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule